// File: doc/BRIEF.md
# Fixed Off-Time Current Chopper

This block regulates winding current in a full-bridge driver by chopping the high-side drive for a fixed interval. While the bridge conducts, the current-sense comparator's trip input clears a source-enable latch. An off-time counter then runs for a fixed number of oscillator periods. During that interval the block tells the bridge whether to recirculate the current in fast or in slow decay. When the counter expires, the latch is set again and a blanking window hides the comparator. This keeps the turn-on current spike from tripping the latch again at once.

The block runs from a fast system clock. Every counter advances only on a one-cycle oscillator tick. A 2-bit mode input chooses the decay profile: slow only, one of two mixed ratios (fast first, slow after), or fast only. The external PWM enable and the direction (phase) input also restart the blanking window. While enable is low the chopper waits and does nothing.

Top module: `chop_fixed_off`

## Requirements
- R1: The off time lasts exactly 96 oscillator ticks. source_enable goes low on the clock edge that accepts a trip. It returns high on the clock edge that consumes the 96th tick after that.
- R2: A trip is accepted when enable is high, source_enable is high and blanking is inactive. Acceptance clears source_enable on the next clock edge.
- R3: The mode input is sampled when the trip is accepted. It sets how many ticks of fast decay start the off time: 2'b00 gives 0, 2'b01 gives 14, 2'b10 gives 46 and 2'b11 gives all 96.
- R4: decay_fast is high only inside the off time. It is high for the first N ticks of the off time and low for the rest, so fast decay always comes before slow decay.
- R5: When the off time ends, blanking goes high on the same clock edge. It stays high for 6 ticks if blank_sel is 0 and for 12 ticks if blank_sel is 1. blank_sel is sampled at the moment blanking is loaded.
- R6: A trip has no effect on source_enable while blanking is active. A trip during a running off time neither restarts nor extends that off time.
- R7: A rising edge of enable, or any change of phase while enable is high, reloads the blanking window on the next clock edge.
- R8: While enable is low, all counters are held at zero. source_enable is high, decay_fast and blanking are low, and trips are ignored.
- R9: With no osc_tick, no counter changes. An off time in progress holds its outputs for as long as the ticks stay absent.
- R10: After reset, source_enable is high and decay_fast and blanking are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| osc_tick | input | 1 | One-cycle pulse per oscillator period |
| trip | input | 1 | Sense comparator output, high at the current limit |
| mode | input | 2 | Decay profile select (see R3) |
| blank_sel | input | 1 | 0: short blanking, 1: long blanking |
| enable | input | 1 | External PWM enable |
| phase | input | 1 | Bridge direction |
| source_enable | output | 1 | High-side driver allowed to conduct |
| decay_fast | output | 1 | 1: fast decay, 0: slow decay during the off time |
| blanking | output | 1 | Comparator masked |

## Verification
A trip, an enable edge or a phase change takes effect one clock edge later, because every output comes from a register one stage behind the input. Each tick-driven result, such as the end of the off time, the end of the fast portion or the end of blanking, is due on the edge that consumes the relevant tick. The bench drives inputs and samples outputs on the falling clock edge. A tick task issues one pulse and then waits until the pulse has been consumed. Each check therefore falls on a whole number of ticks counted from the trip, and the bench walks the off time one tick at a time. It also holds the ticks back for several clocks to show that the outputs stay frozen.

// File: rtl/chop_pkg.sv
// Package: shared decay-profile encoding and the fast-portion length lookup.
// Assumes callers supply the tick counts as parameters of their own.
package chop_pkg;

    typedef enum logic [1:0] {
        DECAY_SLOW      = 2'b00,
        DECAY_MIX_SHORT = 2'b01,
        DECAY_MIX_LONG  = 2'b10,
        DECAY_FAST_ALL  = 2'b11
    } decay_sel_e;

    // Number of fast-decay ticks that open the off time for a given profile.
    function automatic int unsigned fast_ticks(input logic [1:0] sel,
                                               input int unsigned short_n,
                                               input int unsigned long_n,
                                               input int unsigned full_n);
        case (decay_sel_e'(sel))
            DECAY_SLOW:      return 0;
            DECAY_MIX_SHORT: return short_n;
            DECAY_MIX_LONG:  return long_n;
            default:         return full_n;
        endcase
    endfunction

endpackage

// File: rtl/chop_edge_detect.sv
// Module: finds the events that reload the blanking window.
// It flags a rising edge of enable, or any phase change while enable is high.
// Assumes enable and phase are already synchronous to clk.
module chop_edge_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic phase,
    output logic restart
);
    logic en_q;
    logic ph_q;

    // Keep the previous enable and phase values for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= 1'b0;
            ph_q <= 1'b0;
        end else begin
            en_q <= enable;
            ph_q <= phase;
        end
    end

    // Reload request: enable turned on, or direction flipped while on.
    always_comb begin
        restart = (enable & ~en_q) | (enable & (phase ^ ph_q));
    end

    AST_RESTART_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(enable) |-> restart); // R7

    AST_RESTART_ON_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && $past(enable) && (phase != $past(phase))) |-> restart); // R7

endmodule

// File: rtl/chop_offtime.sv
// Module: holds the source-enable latch and runs the fixed off-time and
// fast-portion counters. A trip that is not masked opens an off time of
// OFF_TICKS ticks. Its first FAST ticks (chosen by mode) request fast decay.
// Assumes osc_tick is a single-cycle pulse and that trip_mask covers blanking.
module chop_offtime #(
    parameter int unsigned OFF_TICKS   = 96,
    parameter int unsigned FAST_SHORT  = 14,
    parameter int unsigned FAST_LONG   = 46
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       osc_tick,
    input  logic       enable,
    input  logic       trip,
    input  logic       trip_mask,
    input  logic [1:0] mode,
    output logic       source_enable,
    output logic       decay_fast,
    output logic       off_done
);
    import chop_pkg::*;

    localparam int unsigned CW = $clog2(OFF_TICKS + 1);

    logic [CW-1:0] off_cnt;
    logic [CW-1:0] fast_cnt;
    logic          src_q;
    logic          accept;
    logic [CW-1:0] fast_load;

    // Trip acceptance and the fast length the current mode asks for.
    always_comb begin
        accept    = enable && src_q && (off_cnt == '0) && trip && !trip_mask;
        fast_load = CW'(fast_ticks(mode, FAST_SHORT, FAST_LONG, OFF_TICKS));
        off_done  = enable && osc_tick && (off_cnt == CW'(1));
    end

    // Latch and counters: idle while disabled, load on trip, count on ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            off_cnt  <= '0;
            fast_cnt <= '0;
            src_q    <= 1'b1;
        end else if (!enable) begin
            off_cnt  <= '0;
            fast_cnt <= '0;
            src_q    <= 1'b1;
        end else if (accept) begin
            off_cnt  <= CW'(OFF_TICKS);
            fast_cnt <= fast_load;
            src_q    <= 1'b0;
        end else if (osc_tick && (off_cnt != '0)) begin
            off_cnt <= off_cnt - CW'(1);
            if (fast_cnt != '0) begin
                fast_cnt <= fast_cnt - CW'(1);
            end
            if (off_cnt == CW'(1)) begin
                src_q <= 1'b1;
            end
        end
    end

    // Outputs straight from state.
    always_comb begin
        source_enable = src_q;
        decay_fast    = (fast_cnt != '0);
    end

    AST_TRIP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && src_q && trip && !trip_mask && off_cnt == '0) |=> !source_enable); // R2

    AST_OFF_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && src_q && trip && !trip_mask && off_cnt == '0) |=> (off_cnt == CW'(OFF_TICKS))); // R1

    AST_FAST_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && src_q && trip && !trip_mask && off_cnt == '0)
        |=> (int'(fast_cnt) == int'(fast_ticks($past(mode), FAST_SHORT, FAST_LONG, OFF_TICKS)))); // R3

    AST_FAST_INSIDE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        decay_fast |-> (!source_enable && off_cnt >= fast_cnt)); // R4

    AST_MASK_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && trip_mask && src_q && off_cnt == '0) |=> source_enable); // R6

    AST_IDLE_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (source_enable && !decay_fast)); // R8

    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !osc_tick && off_cnt != '0) |=> $stable(off_cnt)); // R9

endmodule

// File: rtl/chop_blanker.sv
// Module: the blanking window counter. It loads at the end of the off time
// or on a restart event and counts down on oscillator ticks.
// Assumes off_done and restart are single-cycle requests.
module chop_blanker #(
    parameter int unsigned BLANK_SHORT = 6,
    parameter int unsigned BLANK_LONG  = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic osc_tick,
    input  logic enable,
    input  logic blank_sel,
    input  logic off_done,
    input  logic restart,
    output logic blanking
);
    localparam int unsigned MAXB = (BLANK_LONG > BLANK_SHORT) ? BLANK_LONG : BLANK_SHORT;
    localparam int unsigned BW   = $clog2(MAXB + 1);

    logic [BW-1:0] blank_cnt;
    logic [BW-1:0] blank_len;

    // Window length chosen by the select bit.
    always_comb begin
        blank_len = blank_sel ? BW'(BLANK_LONG) : BW'(BLANK_SHORT);
    end

    // Window counter: cleared while disabled, reloaded on request, ticks down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blank_cnt <= '0;
        end else if (!enable) begin
            blank_cnt <= '0;
        end else if (off_done || restart) begin
            blank_cnt <= blank_len;
        end else if (osc_tick && (blank_cnt != '0)) begin
            blank_cnt <= blank_cnt - BW'(1);
        end
    end

    // Active whenever ticks remain.
    always_comb begin
        blanking = (blank_cnt != '0);
    end

    AST_BLANK_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && (off_done || restart))
        |=> (blank_cnt == ($past(blank_sel) ? BW'(BLANK_LONG) : BW'(BLANK_SHORT)))); // R5

    AST_BLANK_OFF_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !blanking); // R8

    AST_BLANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !osc_tick && !off_done && !restart) |=> $stable(blank_cnt)); // R9

endmodule

// File: rtl/chop_fixed_off.sv
// Module: top of the fixed off-time chopper. It joins the edge detector, the
// off-time latch/counters and the blanking window. The comparator is masked
// during blanking and on the very edge a blanking restart is requested.
// Assumes all inputs are synchronous to clk.
module chop_fixed_off #(
    parameter int unsigned OFF_TICKS   = 96,
    parameter int unsigned FAST_SHORT  = 14,
    parameter int unsigned FAST_LONG   = 46,
    parameter int unsigned BLANK_SHORT = 6,
    parameter int unsigned BLANK_LONG  = 12
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       osc_tick,
    input  logic       trip,
    input  logic [1:0] mode,
    input  logic       blank_sel,
    input  logic       enable,
    input  logic       phase,
    output logic       source_enable,
    output logic       decay_fast,
    output logic       blanking
);
    logic restart;
    logic off_done;
    logic trip_mask;

    // Comparator mask: window active or about to be reloaded.
    always_comb begin
        trip_mask = blanking | restart;
    end

    chop_edge_detect u_edges (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (enable),
        .phase   (phase),
        .restart (restart)
    );

    chop_offtime #(
        .OFF_TICKS  (OFF_TICKS),
        .FAST_SHORT (FAST_SHORT),
        .FAST_LONG  (FAST_LONG)
    ) u_off (
        .clk           (clk),
        .rst_n         (rst_n),
        .osc_tick      (osc_tick),
        .enable        (enable),
        .trip          (trip),
        .trip_mask     (trip_mask),
        .mode          (mode),
        .source_enable (source_enable),
        .decay_fast    (decay_fast),
        .off_done      (off_done)
    );

    chop_blanker #(
        .BLANK_SHORT (BLANK_SHORT),
        .BLANK_LONG  (BLANK_LONG)
    ) u_blank (
        .clk       (clk),
        .rst_n     (rst_n),
        .osc_tick  (osc_tick),
        .enable    (enable),
        .blank_sel (blank_sel),
        .off_done  (off_done),
        .restart   (restart),
        .blanking  (blanking)
    );

    AST_RESET_STATE: assert property (@(posedge clk)
        $past(!rst_n) |-> (source_enable && !decay_fast && !blanking)); // R10

endmodule

// File: tb/test_chop_fixed_off.sv
// Directed bench for chop_fixed_off: one task per scenario, each checking itself.
module test_chop_fixed_off;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       osc_tick = 1'b0;
    logic       trip = 1'b0;
    logic [1:0] mode = 2'b00;
    logic       blank_sel = 1'b0;
    logic       enable = 1'b0;
    logic       phase = 1'b0;
    logic       source_enable;
    logic       decay_fast;
    logic       blanking;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit done     = 0;

    always #10 clk = ~clk;

    chop_fixed_off i_chop_fixed_off (
        .clk           (clk),
        .rst_n         (rst_n),
        .osc_tick      (osc_tick),
        .trip          (trip),
        .mode          (mode),
        .blank_sel     (blank_sel),
        .enable        (enable),
        .phase         (phase),
        .source_enable (source_enable),
        .decay_fast    (decay_fast),
        .blanking      (blanking)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic tick(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk) osc_tick = 1'b1;
            @(negedge clk) osc_tick = 1'b0;
            repeat (2) @(negedge clk);
        end
    endtask

    task automatic pulse_trip();
        @(negedge clk) trip = 1'b1;
        @(negedge clk) trip = 1'b0;
    endtask

    // R10: outputs after reset.
    task automatic t_reset();
        chk("R10", "source_enable", source_enable, 1'b1);
        chk("R10", "decay_fast", decay_fast, 1'b0);
        chk("R10", "blanking", blanking, 1'b0);
    endtask

    // R7: enable rise opens a blanking window of the selected length (R5 length rule).
    task automatic t_enable_on(input logic bsel);
        int len = bsel ? 12 : 6;
        blank_sel = bsel;
        @(negedge clk) enable = 1'b1;
        @(negedge clk);
        chk("R7", "blanking after enable rise", blanking, 1'b1);
        pulse_trip();
        chk("R6", "trip in enable blanking", source_enable, 1'b1);
        tick(len - 1);
        chk("R7", "blanking before last tick", blanking, 1'b1);
        tick(1);
        chk("R7", "blanking after window", blanking, 1'b0);
    endtask

    // R1 R3 R4 R5 R6 R9: one full off time followed by its blanking window.
    task automatic t_offtime(input logic [1:0] m, input logic bsel, input bit twist);
        int fast_n = (m == 2'b00) ? 0 : (m == 2'b01) ? 14 : (m == 2'b10) ? 46 : 96;
        int len = bsel ? 12 : 6;
        mode = m;
        blank_sel = bsel;
        pulse_trip();
        chk("R2", "source_enable after trip", source_enable, 1'b0);
        if (twist) mode = 2'b00; // R3: mode sampled at trip only
        for (int i = 0; i < 96; i++) begin
            chk("R4", "decay_fast profile", decay_fast, (i < fast_n) ? 1'b1 : 1'b0);
            chk("R1", "source_enable in off", source_enable, 1'b0);
            if (twist && i == 30) begin
                pulse_trip();
                chk("R6", "trip during off time", source_enable, 1'b0);
            end
            if (twist && i == 50) begin
                repeat (8) @(negedge clk);
                chk("R9", "held without ticks", source_enable, 1'b0);
                chk("R9", "decay held without ticks", decay_fast, (i < fast_n) ? 1'b1 : 1'b0);
            end
            tick(1);
        end
        chk("R1", "source_enable after 96 ticks", source_enable, 1'b1);
        chk("R4", "decay_fast after off", decay_fast, 1'b0);
        chk("R5", "blanking at off end", blanking, 1'b1);
        tick(len - 1);
        chk("R5", "blanking before last tick", blanking, 1'b1);
        pulse_trip();
        chk("R6", "trip during blanking", source_enable, 1'b1);
        tick(1);
        chk("R5", "blanking ended", blanking, 1'b0);
    endtask

    // R7: phase change restarts blanking while on.
    task automatic t_phase();
        blank_sel = 1'b0;
        @(negedge clk) phase = ~phase;
        @(negedge clk);
        chk("R7", "blanking after phase change", blanking, 1'b1);
        pulse_trip();
        chk("R6", "trip after phase change", source_enable, 1'b1);
        tick(6);
        chk("R7", "phase blanking ended", blanking, 1'b0);
    endtask

    // R8: enable low aborts the off time and ignores trips.
    task automatic t_disable();
        mode = 2'b11;
        pulse_trip();
        chk("R2", "trip before disable", source_enable, 1'b0);
        tick(20);
        chk("R4", "fast mid off", decay_fast, 1'b1);
        @(negedge clk) enable = 1'b0;
        @(negedge clk);
        chk("R8", "source_enable when disabled", source_enable, 1'b1);
        chk("R8", "decay_fast when disabled", decay_fast, 1'b0);
        chk("R8", "blanking when disabled", blanking, 1'b0);
        pulse_trip();
        chk("R8", "trip while disabled", source_enable, 1'b1);
        tick(100);
        chk("R8", "idle after ticks", source_enable, 1'b1);
        chk("R8", "no blanking idle", blanking, 1'b0);
    endtask

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cycles++;
        if (!done && cycles > 150000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected under 150000", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_enable_on(1'b0);
        t_offtime(2'b00, 1'b0, 1'b1);
        t_offtime(2'b01, 1'b1, 1'b0);
        t_offtime(2'b10, 1'b0, 1'b1);
        t_offtime(2'b11, 1'b1, 1'b0);
        t_phase();
        t_disable();
        t_enable_on(1'b1);
        t_offtime(2'b01, 1'b0, 1'b0);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule